// File: doc/BRIEF.md
# Program-Counter Call Stack

This block keeps the program counter of a small processor core in a ring of eight 14-bit registers. A 3-bit pointer selects the register that acts as the live program counter. The block has no stack in memory. A subroutine call advances the pointer and loads the target into the newly selected register, so the return address stays in the register below it. A return steps the pointer back, and execution resumes from the address held there.

After each fetch the sequencer pulses a fetch-advance input with a byte-count code. The block adds that count to the live register only. Jump and call targets arrive as two operand bytes. The first byte holds target bits 7:0. The low six bits of the second byte hold target bits 13:8, and its top two bits are dropped.

The current program counter is a combinational read of the selected register. Every operation therefore becomes visible on the output in the cycle after the edge that takes it.

Top module: `pc_call_stack`

## Requirements
- R1: While reset is high, and after it, the pointer is 0 and all eight registers are 0, so `pc_o` reads 0.
- R2: When `adv_i` is high with `len_i` = 1, 2 or 3, the live register gains that many bytes modulo 2^14. A `len_i` of 0 leaves every register unchanged.
- R3: When `jmp_i` is high, the live register loads the target `{tgt_hi_i[5:0], tgt_lo_i}` and the pointer does not move. Bits 7:6 of `tgt_hi_i` have no effect.
- R4: When `call_i` is high, the pointer increments modulo 8 and the newly selected register loads the target, built the same way as in R3. The register it left keeps its value as the return address.
- R5: When `ret_i` is high, the pointer decrements modulo 8 and `pc_o` shows the value held in the entry below, with no register written.
- R6: Nine nested calls wrap the pointer past 7 and silently overwrite the oldest entry. No flag is raised.
- R7: A return taken while the pointer is 0 wraps it to 7 and shows that register's content.
- R8: When several strobes are high in one cycle, only one operation happens. The priority is call, then jump, then return, then advance.
- R9: An advance, a jump or a call writes at most one register. Every entry other than the written one keeps its value.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock, rising edge |
| rst | input | 1 | Synchronous active-high reset |
| adv_i | input | 1 | Fetch-advance strobe |
| len_i | input | 2 | Byte count to add on advance (0 to 3) |
| jmp_i | input | 1 | Jump strobe |
| call_i | input | 1 | Call strobe |
| ret_i | input | 1 | Return strobe |
| tgt_lo_i | input | 8 | Target bits 7:0 |
| tgt_hi_i | input | 8 | Target bits 13:8 in bits 5:0; bits 7:6 ignored |
| pc_o | output | 14 | Currently selected program counter |

## Verification
Each operation is registered on one rising edge, and its result is due on `pc_o` at the following falling edge. The bench therefore holds its strobes across a single rising edge, clears them at the next falling edge, and compares `pc_o` there against an arithmetic model of the eight registers and the pointer. Return addresses, wrapped entries and the entries that an advance must leave alone cannot be seen directly. Later returns bring them onto `pc_o`, one cycle per return.

// File: rtl/pcs_pkg.sv
package pcs_pkg;
    localparam int PCS_PC_W  = 14;
    localparam int PCS_DEPTH = 8;
    localparam int PCS_PTR_W = $clog2(PCS_DEPTH);
    localparam int PCS_HI_W  = PCS_PC_W - 8;

    typedef logic [PCS_PC_W-1:0]  pc_t;
    typedef logic [PCS_PTR_W-1:0] ptr_t;

    typedef enum logic [2:0] {
        OP_NONE,
        OP_ADV,
        OP_JUMP,
        OP_CALL,
        OP_RET
    } op_e;

    function automatic pc_t build_target(input logic [7:0] lo, input logic [7:0] hi);
        return {hi[PCS_HI_W-1:0], lo};
    endfunction

    function automatic pc_t add_len(input pc_t pc, input logic [1:0] len);
        return pc + pc_t'(len);
    endfunction
endpackage

// File: rtl/pcs_op_select.sv
module pcs_op_select
    import pcs_pkg::*;
(
    input  logic       adv,
    input  logic [1:0] len,
    input  logic       jmp,
    input  logic       call,
    input  logic       ret,
    output op_e        op
);
    always_comb begin
        if (call)                   op = OP_CALL;
        else if (jmp)               op = OP_JUMP;
        else if (ret)               op = OP_RET;
        else if (adv && len != 2'd0) op = OP_ADV;
        else                        op = OP_NONE;
    end
endmodule

// File: rtl/pcs_ptr.sv
module pcs_ptr
    import pcs_pkg::*;
(
    input  logic clk,
    input  logic rst,
    input  op_e  op,
    output ptr_t ptr_q,
    output ptr_t ptr_up
);
    assign ptr_up = ptr_q + ptr_t'(1);

    always_ff @(posedge clk) begin
        if (rst)                 ptr_q <= '0;
        else if (op == OP_CALL)  ptr_q <= ptr_up;
        else if (op == OP_RET)   ptr_q <= ptr_q - ptr_t'(1);
    end
endmodule

// File: rtl/pcs_pc_bank.sv
module pcs_pc_bank
    import pcs_pkg::*;
(
    input  logic clk,
    input  logic rst,
    input  logic wr_en,
    input  ptr_t wr_idx,
    input  pc_t  wr_data,
    input  ptr_t rd_idx,
    output pc_t  rd_data
);
    pc_t entry_q [PCS_DEPTH];

    for (genvar g = 0; g < PCS_DEPTH; g++) begin : g_entry
        always_ff @(posedge clk) begin
            if (rst)
                entry_q[g] <= '0;
            else if (wr_en && wr_idx == ptr_t'(g))
                entry_q[g] <= wr_data;
        end
    end

    assign rd_data = entry_q[rd_idx];
endmodule

// File: rtl/pc_call_stack.sv
module pc_call_stack
    import pcs_pkg::*;
(
    input  logic        clk,
    input  logic        rst,
    input  logic        adv_i,
    input  logic [1:0]  len_i,
    input  logic        jmp_i,
    input  logic        call_i,
    input  logic        ret_i,
    input  logic [7:0]  tgt_lo_i,
    input  logic [7:0]  tgt_hi_i,
    output logic [13:0] pc_o
);
    op_e  op;
    ptr_t ptr_q;
    ptr_t ptr_up;
    pc_t  active;
    pc_t  target;
    logic wr_en;
    ptr_t wr_idx;
    pc_t  wr_data;

    pcs_op_select u_sel (
        .adv  (adv_i),
        .len  (len_i),
        .jmp  (jmp_i),
        .call (call_i),
        .ret  (ret_i),
        .op   (op)
    );

    pcs_ptr u_ptr (
        .clk    (clk),
        .rst    (rst),
        .op     (op),
        .ptr_q  (ptr_q),
        .ptr_up (ptr_up)
    );

    assign target = build_target(tgt_lo_i, tgt_hi_i);

    always_comb begin
        wr_en   = 1'b0;
        wr_idx  = ptr_q;
        wr_data = target;
        unique case (op)
            OP_CALL: begin wr_en = 1'b1; wr_idx = ptr_up; end
            OP_JUMP: wr_en = 1'b1;
            OP_ADV:  begin wr_en = 1'b1; wr_data = add_len(active, len_i); end
            default: wr_en = 1'b0;
        endcase
    end

    pcs_pc_bank u_bank (
        .clk     (clk),
        .rst     (rst),
        .wr_en   (wr_en),
        .wr_idx  (wr_idx),
        .wr_data (wr_data),
        .rd_idx  (ptr_q),
        .rd_data (active)
    );

    assign pc_o = active;
endmodule

// File: rtl/pcs_checker.sv
module pcs_checker (
    input logic        clk,
    input logic        rst,
    input logic        adv,
    input logic [1:0]  len,
    input logic        jmp,
    input logic        call,
    input logic        ret,
    input logic [7:0]  lo,
    input logic [7:0]  hi,
    input logic [2:0]  ptr,
    input logic [13:0] pc
);
    // R1: the first cycle out of reset shows slot 0 cleared
    assert_reset_clear_R1: assert property (@(posedge clk) disable iff (rst)
        $past(rst) |-> (pc == 14'd0 && ptr == 3'd0));

    // R2: a lone advance adds the byte count modulo 2^14
    assert_adv_sum_R2: assert property (@(posedge clk) disable iff (rst)
        (adv && len != 2'd0 && !call && !jmp && !ret) |=>
        (pc == 14'($past(pc) + 14'($past(len)))));

    // R3: a jump loads the assembled target and leaves the pointer in place
    assert_jump_load_R3: assert property (@(posedge clk) disable iff (rst)
        (jmp && !call) |=> (pc == {$past(hi[5:0]), $past(lo)} && $stable(ptr)));

    // R4, R6: a call steps the pointer up with wrap, no stall at 7
    assert_call_ptr_R4: assert property (@(posedge clk) disable iff (rst)
        call |=> (ptr == 3'($past(ptr) + 3'd1) && pc == {$past(hi[5:0]), $past(lo)}));

    // R5, R7: a lone return steps the pointer down with wrap
    assert_ret_ptr_R5: assert property (@(posedge clk) disable iff (rst)
        (ret && !call && !jmp) |=> (ptr == 3'($past(ptr) - 3'd1)));

    // R8: with no strobe active, nothing changes
    assert_idle_hold_R8: assert property (@(posedge clk) disable iff (rst)
        (!call && !jmp && !ret && !(adv && len != 2'd0)) |=> ($stable(pc) && $stable(ptr)));
endmodule

bind pc_call_stack pcs_checker u_chk (
    .clk  (clk),
    .rst  (rst),
    .adv  (adv_i),
    .len  (len_i),
    .jmp  (jmp_i),
    .call (call_i),
    .ret  (ret_i),
    .lo   (tgt_lo_i),
    .hi   (tgt_hi_i),
    .ptr  (ptr_q),
    .pc   (pc_o)
);

// File: tb/tb_pc_call_stack.sv
module tb_pc_call_stack;
    localparam int CLK_PERIOD = 10;

    logic        clk = 1'b0;
    logic        rst = 1'b1;
    logic        adv_i = 1'b0;
    logic [1:0]  len_i = 2'd0;
    logic        jmp_i = 1'b0;
    logic        call_i = 1'b0;
    logic        ret_i = 1'b0;
    logic [7:0]  tgt_lo_i = 8'd0;
    logic [7:0]  tgt_hi_i = 8'd0;
    logic [13:0] pc_o;

    int errors = 0;
    int checks = 0;
    logic [13:0] m [8];
    int mp = 0;
    logic [31:0] seed = 32'h1234_5678;

    always #(CLK_PERIOD/2) clk = ~clk;

    pc_call_stack dut (
        .clk(clk), .rst(rst), .adv_i(adv_i), .len_i(len_i), .jmp_i(jmp_i),
        .call_i(call_i), .ret_i(ret_i), .tgt_lo_i(tgt_lo_i), .tgt_hi_i(tgt_hi_i),
        .pc_o(pc_o)
    );

    task automatic check(input string tag, input logic [13:0] got, input logic [13:0] exp);
        checks++;
        if (got !== exp) begin
            errors++;
            $display("FAIL %s pc_o=%h expected=%h", tag, got, exp);
        end
    endtask

    // one operation: drive at falling edge, take at rising edge, check at next falling edge
    task automatic step(input string tag, input logic a, input logic [1:0] l,
                        input logic j, input logic c, input logic r,
                        input logic [7:0] lo, input logic [7:0] hi);
        logic [13:0] t;
        adv_i = a; len_i = l; jmp_i = j; call_i = c; ret_i = r;
        tgt_lo_i = lo; tgt_hi_i = hi;
        @(posedge clk);
        t = {hi[5:0], lo};
        if (c) begin mp = (mp + 1) % 8; m[mp] = t; end
        else if (j) m[mp] = t;
        else if (r) mp = (mp + 7) % 8;
        else if (a && l != 2'd0) m[mp] = 14'(m[mp] + 14'(l));
        @(negedge clk);
        adv_i = 0; len_i = 0; jmp_i = 0; call_i = 0; ret_i = 0;
        check(tag, pc_o, m[mp]);
    endtask

    initial begin
        repeat (200000) @(posedge clk);
        errors++;
        $display("FAIL watchdog expired");
        $display("Result: errors=%0d of %0d checks", errors, checks);
        $finish;
    end

    initial begin
        for (int i = 0; i < 8; i++) m[i] = 14'd0;
        repeat (3) @(negedge clk);
        check("R1 during reset", pc_o, 14'd0);
        rst = 1'b0;
        @(negedge clk);
        check("R1 after reset", pc_o, 14'd0);
        // R7: return at slot 0 wraps to 7, which reset cleared (R1)
        step("R7 underflow", 0, 0, 0, 0, 1, 8'h00, 8'h00);
        step("R1 slot7 clear", 0, 0, 0, 0, 0, 8'h00, 8'h00);
        step("R4 back to 0", 0, 0, 0, 1, 0, 8'h00, 8'h00);

        // R2: every length, including 0, and wrap past 2^14
        for (int l = 0; l < 4; l++) step("R2 len sweep", 1, 2'(l), 0, 0, 0, 8'h00, 8'h00);
        for (int l = 0; l < 4; l++) begin
            step("R3 jump near top", 0, 0, 1, 0, 0, 8'hFE, 8'h3F);
            step("R2 wrap", 1, 2'(l), 0, 0, 0, 8'h00, 8'h00);
        end

        // R3: top bits of the high byte ignored
        for (int h = 0; h < 4; h++)
            step("R3 hi[7:6] ignored", 0, 0, 1, 0, 0, 8'hA5, 8'(h << 6) | 8'h15);

        // R4/R5/R9: call, advance inside callee, return sees untouched caller
        step("R2 caller adv", 1, 2'd3, 0, 0, 0, 8'h00, 8'h00);
        step("R4 call", 0, 0, 0, 1, 0, 8'h34, 8'h12);
        step("R9 callee adv", 1, 2'd2, 0, 0, 0, 8'h00, 8'h00);
        step("R5 return", 0, 0, 0, 0, 1, 8'h00, 8'h00);

        // R6: nine nested calls overwrite the oldest, then ten returns
        for (int k = 0; k < 9; k++) step("R6 nest", 0, 0, 0, 1, 0, 8'(k * 17), 8'(k));
        for (int k = 0; k < 10; k++) step("R6 unwind", 0, 0, 0, 0, 1, 8'h00, 8'h00);

        // R8: every strobe combination with advance length 2
        for (int s = 0; s < 16; s++)
            step("R8 priority", s[0], 2'd2, s[1], s[2], s[3], 8'(s * 11 + 3), 8'(s * 29));

        // R8/R9: long pseudo-random mix against the model
        for (int n = 0; n < 3000; n++) begin
            seed = seed ^ (seed << 13); seed = seed ^ (seed >> 17); seed = seed ^ (seed << 5);
            step("R8 random", seed[0] | seed[1], seed[3:2], seed[4] & seed[5],
                 seed[6] & seed[7] & seed[8], seed[9] & seed[10] & seed[11],
                 seed[19:12], seed[27:20]);
        end

        $display("Result: errors=%0d of %0d checks", errors, checks);
        $finish;
    end
endmodule